// File: doc/BRIEF.md
# Pointer Candidate Line Scanner

The scanner sits beside a cache fill path. When a 64-byte line arrives it also receives the virtual address of the request that caused the fill, that request's chain depth, and a flag that marks fills made by the hardware page-table walker. Every 2-byte-aligned 32-bit slice of the line is examined in the same cycle. A slice counts as a pointer candidate when it appears to share a base region with the triggering address. Two extra tests apply near the bottom and the top of the address space: a slice there must carry real address bits just below the compared field. A slice that is not aligned is rejected.

Candidates that point into the same 64-byte target line are reduced to one request. The surviving requests are held in a small pending set and offered one per cycle on a valid/ready port, lowest line offset first. Each request carries the target line address and a child depth one deeper than the fill. The scanner accepts a new fill only when every pending request of the previous line has left, so the fill side stalls through `fill_ready`. Compare width, filter width, alignment width, scan step and depth limit are parameters.

Top module: `ptr_line_scanner`

## Requirements
- R1: After reset, `req_valid` is 0 and `fill_ready` is 1.
- R2: The window at even byte offset o (0 to 60) is `fill_line[8*o+31 : 8*o]`, so byte o is its least significant byte. A window qualifies only when its bits 31:24 equal bits 31:24 of `fill_vaddr` and its bit 0 is 0.
- R3: When bits 31:24 of a window are all zero, the window qualifies only if bits 23:20 are not all zero.
- R4: When bits 31:24 of a window are all one, the window qualifies only if bits 23:20 are not all one.
- R5: A fill accepted with `fill_walk` = 1 produces no request.
- R6: A fill accepted with `fill_depth` = 3, the depth limit, produces no request.
- R7: Each request carries `req_addr` equal to the candidate with bits 5:0 cleared, and `req_depth` equal to `fill_depth` + 1.
- R8: Requests leave in ascending window offset. The first one is offered in the cycle after the fill is accepted. With `req_ready` held at 1, a new request is offered every cycle.
- R9: Candidates of one fill that share a target line produce exactly one request, placed at the position of the lowest-offset candidate.
- R10: While `req_valid` is 1 and `req_ready` is 0, the request holds steady and `fill_ready` stays 0. `fill_ready` returns to 1 once the last request has been taken.
- R11: The first window (offset 0) and the last window (offset 60) are both examined, and a line can yield as many as 16 separate requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_valid | input | 1 | A fill line is presented |
| fill_ready | output | 1 | Scanner can take a fill (no requests pending) |
| fill_line | input | 512 | Fill data, byte 0 in bits 7:0 |
| fill_vaddr | input | 32 | Virtual address of the triggering request |
| fill_depth | input | 2 | Chain depth of the triggering request |
| fill_walk | input | 1 | Fill comes from the page-table walker; skip scan |
| req_valid | output | 1 | A prefetch request is offered |
| req_ready | input | 1 | Consumer takes the offered request |
| req_addr | output | 32 | Target line address (bits 5:0 zero) |
| req_depth | output | 2 | Chain depth of the request |

## Verification
Lines are tried with a single pointer, with two pointers into one target line, with two pointers into separate lines placed out of order, and with a misaligned pointer. Each of these separates the compare test, the merging and the ordering from one another. Lines whose trigger address lies in the lowest and the highest regions place one value that passes the filter and one that fails it, which shows whether the filter depends on the region. The same valid pointer is also sent with the walker flag and with depth at the limit, which isolates the two bypass paths. A line packed with 16 distinct pointers under held back-pressure exercises the edge windows, the hold behaviour and the refusal of a new fill while requests are pending.

// File: rtl/pcs_pkg.sv
// Package: shared defaults and types for the pointer candidate line scanner.
// Assumes: nothing beyond standard SystemVerilog.
package pcs_pkg;

    localparam int DEF_LINE_BYTES  = 64;
    localparam int DEF_ADDR_W      = 32;
    localparam int DEF_STEP_BYTES  = 2;
    localparam int DEF_CMP_BITS    = 8;
    localparam int DEF_FLT_BITS    = 4;
    localparam int DEF_ALIGN_BITS  = 1;
    localparam int DEF_DEPTH_W     = 2;
    localparam int DEF_DEPTH_LIMIT = 3;

    // Address-space region of a window, from its compared high bits.
    typedef enum logic [1:0] {
        REG_MID  = 2'd0,
        REG_LOW  = 2'd1,
        REG_HIGH = 2'd2
    } region_e;

endpackage

// File: rtl/pcs_window_check.sv
// Module: classifies one address-sized window as a pointer candidate.
// The high compare field must match the trigger. In the all-zero and
// all-one regions the filter field must hold a bit that differs from
// the region value. The align bits must be zero.
// Assumes: CMP_BITS + FLT_BITS + ALIGN_BITS <= ADDR_W. FLT_BITS = 0
// disables prediction in both extreme regions.
module pcs_window_check #(
    parameter int ADDR_W     = pcs_pkg::DEF_ADDR_W,
    parameter int CMP_BITS   = pcs_pkg::DEF_CMP_BITS,
    parameter int FLT_BITS   = pcs_pkg::DEF_FLT_BITS,
    parameter int ALIGN_BITS = pcs_pkg::DEF_ALIGN_BITS
) (
    input  logic [ADDR_W-1:0]   word,
    input  logic [CMP_BITS-1:0] trig_hi,
    output logic                hit
);
    import pcs_pkg::*;

    logic [CMP_BITS-1:0] hi;
    logic                low_ok;
    logic                high_ok;
    logic                align_ok;
    region_e             region;
    logic                unused_word;

    assign hi          = word[ADDR_W-1 -: CMP_BITS];
    assign unused_word = ^word;

    // Region of the window, from its compared field.
    always_comb begin
        if (hi == '0)      region = REG_LOW;
        else if (&hi)      region = REG_HIGH;
        else               region = REG_MID;
    end

    generate
        if (FLT_BITS > 0) begin : g_filter
            logic [FLT_BITS-1:0] flt;
            assign flt     = word[ADDR_W-CMP_BITS-1 -: FLT_BITS];
            assign low_ok  = |flt;
            assign high_ok = ~&flt;
        end else begin : g_no_filter
            assign low_ok  = 1'b0;
            assign high_ok = 1'b0;
        end

        if (ALIGN_BITS > 0) begin : g_align
            assign align_ok = (word[ALIGN_BITS-1:0] == '0);
        end else begin : g_no_align
            assign align_ok = 1'b1;
        end
    endgenerate

    // Final verdict: base match, alignment and region filter.
    always_comb begin
        hit = (hi == trig_hi) && align_ok;
        case (region)
            REG_LOW:  hit = hit && low_ok;
            REG_HIGH: hit = hit && high_ok;
            default:  hit = hit;
        endcase
    end

endmodule

// File: rtl/pcs_line_merge.sv
// Module: drops each candidate whose target line also belongs to a
// lower-indexed candidate, so every target line survives only once,
// at its first position.
// Assumes: index order is the window offset order.
module pcs_line_merge #(
    parameter int N    = 31,
    parameter int LA_W = 26
) (
    input  logic [N-1:0]           hits,
    input  logic [N-1:0][LA_W-1:0] lines,
    output logic [N-1:0]           keep
);
    // Pairwise compare against every earlier candidate.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            keep[i] = hits[i];
            for (int j = 0; j < i; j++) begin
                if (hits[j] && (lines[j] == lines[i])) keep[i] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/pcs_issue_queue.sv
// Module: holds the surviving candidates of one line and offers them
// one per cycle, lowest index first, on a valid/ready port.
// Assumes: load only happens when empty is high.
module pcs_issue_queue #(
    parameter int N       = 31,
    parameter int ADDR_W  = pcs_pkg::DEF_ADDR_W,
    parameter int LA_W    = 26,
    parameter int DEPTH_W = pcs_pkg::DEF_DEPTH_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [N-1:0]           load_mask,
    input  logic [N-1:0][LA_W-1:0] load_lines,
    input  logic [DEPTH_W-1:0]     load_depth,
    output logic                   req_valid,
    input  logic                   req_ready,
    output logic [ADDR_W-1:0]      req_addr,
    output logic [DEPTH_W-1:0]     req_depth,
    output logic                   empty
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam int OFF_W = ADDR_W - LA_W;

    logic [N-1:0]           pend_q;
    logic [N-1:0][LA_W-1:0] lines_q;
    logic [DEPTH_W-1:0]     depth_q;
    logic [IDX_W-1:0]       sel;
    logic                   found;

    // Lowest pending index picks the next request.
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (pend_q[i] && !found) begin
                sel   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    assign req_valid = found;
    assign req_addr  = {lines_q[sel], {OFF_W{1'b0}}};
    assign req_depth = depth_q;
    assign empty     = ~found;

    // Pending set: loaded per fill, one bit cleared per handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            depth_q <= '0;
        end else if (load) begin
            pend_q  <= load_mask;
            depth_q <= load_depth;
        end else if (found && req_ready) begin
            pend_q[sel] <= 1'b0;
        end
    end

    // Target line storage, captured with each fill.
    always_ff @(posedge clk) begin
        if (load) lines_q <= load_lines;
    end

endmodule

// File: rtl/ptr_line_scanner.sv
// Module: top of the pointer candidate line scanner. It splits the fill
// line into overlapping windows, classifies all of them in parallel,
// gates the result for walker fills and depth-limited fills, merges
// candidates that share a target line and queues the rest for issue.
// Assumes: a fill is taken only when no requests are pending.
module ptr_line_scanner #(
    parameter int LINE_BYTES  = pcs_pkg::DEF_LINE_BYTES,
    parameter int ADDR_W      = pcs_pkg::DEF_ADDR_W,
    parameter int STEP_BYTES  = pcs_pkg::DEF_STEP_BYTES,
    parameter int CMP_BITS    = pcs_pkg::DEF_CMP_BITS,
    parameter int FLT_BITS    = pcs_pkg::DEF_FLT_BITS,
    parameter int ALIGN_BITS  = pcs_pkg::DEF_ALIGN_BITS,
    parameter int DEPTH_W     = pcs_pkg::DEF_DEPTH_W,
    parameter int DEPTH_LIMIT = pcs_pkg::DEF_DEPTH_LIMIT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fill_valid,
    output logic                    fill_ready,
    input  logic [LINE_BYTES*8-1:0] fill_line,
    input  logic [ADDR_W-1:0]       fill_vaddr,
    input  logic [DEPTH_W-1:0]      fill_depth,
    input  logic                    fill_walk,
    output logic                    req_valid,
    input  logic                    req_ready,
    output logic [ADDR_W-1:0]       req_addr,
    output logic [DEPTH_W-1:0]      req_depth
);
    localparam int WORD_BYTES = ADDR_W / 8;
    localparam int N_WIN      = (LINE_BYTES - WORD_BYTES) / STEP_BYTES + 1;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int LA_W       = ADDR_W - OFF_W;

    logic [N_WIN-1:0]           raw_hit;
    logic [N_WIN-1:0]           gated_hit;
    logic [N_WIN-1:0]           keep;
    logic [N_WIN-1:0][LA_W-1:0] win_line;
    logic                       scan_en;
    logic                       load;
    logic                       q_empty;
    logic [DEPTH_W-1:0]         child_depth;
    logic                       unused_vaddr_low;

    assign unused_vaddr_low = ^fill_vaddr[ADDR_W-CMP_BITS-1:0];

    // One classifier per window, all evaluated in the same cycle.
    generate
        for (genvar w = 0; w < N_WIN; w++) begin : g_win
            logic [ADDR_W-1:0] word;
            assign word        = fill_line[w*STEP_BYTES*8 +: ADDR_W];
            assign win_line[w] = word[ADDR_W-1:OFF_W];
            pcs_window_check #(
                .ADDR_W     (ADDR_W),
                .CMP_BITS   (CMP_BITS),
                .FLT_BITS   (FLT_BITS),
                .ALIGN_BITS (ALIGN_BITS)
            ) i_check (
                .word    (word),
                .trig_hi (fill_vaddr[ADDR_W-1 -: CMP_BITS]),
                .hit     (raw_hit[w])
            );
        end
    endgenerate

    // Bypass for walker fills and fills already at the depth limit.
    assign scan_en     = !fill_walk && (fill_depth < DEPTH_W'(DEPTH_LIMIT));
    assign gated_hit   = raw_hit & {N_WIN{scan_en}};
    assign child_depth = fill_depth + 1'b1;
    assign load        = fill_valid && fill_ready;
    assign fill_ready  = q_empty;

    pcs_line_merge #(
        .N    (N_WIN),
        .LA_W (LA_W)
    ) i_merge (
        .hits  (gated_hit),
        .lines (win_line),
        .keep  (keep)
    );

    pcs_issue_queue #(
        .N       (N_WIN),
        .ADDR_W  (ADDR_W),
        .LA_W    (LA_W),
        .DEPTH_W (DEPTH_W)
    ) i_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_mask  (keep),
        .load_lines (win_line),
        .load_depth (child_depth),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_depth  (req_depth),
        .empty      (q_empty)
    );

endmodule

// File: rtl/pcs_scan_checker.sv
// Module: protocol and bypass properties of the scanner, bound to the top.
// Assumes: synchronous active-low reset on rst_n.
module pcs_scan_checker #(
    parameter int ADDR_W      = 32,
    parameter int DEPTH_W     = 2,
    parameter int OFF_W       = 6,
    parameter int DEPTH_LIMIT = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fill_valid,
    input logic               fill_ready,
    input logic               fill_walk,
    input logic [DEPTH_W-1:0] fill_depth,
    input logic               req_valid,
    input logic               req_ready,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [DEPTH_W-1:0] req_depth
);
    // R10: a stalled request keeps its content.
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_depth));

    // R10: no fill is taken while requests are pending.
    a_r10_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !fill_ready);

    // R5: walker fills leave nothing behind.
    a_r5_walk_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && fill_ready && fill_walk |=> !req_valid);

    // R6: fills at the depth limit leave nothing behind.
    a_r6_depth_limit: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && fill_ready && (fill_depth >= DEPTH_W'(DEPTH_LIMIT)) |=> !req_valid);

    // R7: requests are line aligned and at least one link deep.
    a_r7_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[OFF_W-1:0] == '0) && (req_depth != '0));

endmodule

bind ptr_line_scanner pcs_scan_checker #(
    .ADDR_W      (ADDR_W),
    .DEPTH_W     (DEPTH_W),
    .OFF_W       (OFF_W),
    .DEPTH_LIMIT (DEPTH_LIMIT)
) i_pcs_scan_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_valid (fill_valid),
    .fill_ready (fill_ready),
    .fill_walk  (fill_walk),
    .fill_depth (fill_depth),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_depth  (req_depth)
);

// File: tb/test_ptr_line_scanner.sv
// Bench: table-driven fills with a reference scan model, then directed
// tests for reset, back-pressure and a fully populated line.
module test_ptr_line_scanner;
    localparam int CLK_PERIOD = 10;
    localparam int NV         = 9;

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  dep;
        logic        walk;
        logic [5:0]  o0;
        logic [31:0] v0;
        logic [5:0]  o1;
        logic [31:0] v1;
    } vec_t;

    localparam vec_t VECS [0:NV-1] = '{
        '{32'h10000080, 2'd0, 1'b0, 6'd8,  32'h10001248, 6'd0,  32'h0},
        '{32'h10000080, 2'd1, 1'b0, 6'd8,  32'h10001248, 6'd20, 32'h10001270},
        '{32'h10000080, 2'd0, 1'b0, 6'd40, 32'h10002000, 6'd4,  32'h10000100},
        '{32'h10000080, 2'd0, 1'b0, 6'd8,  32'h10001249, 6'd0,  32'h0},
        '{32'h10000080, 2'd3, 1'b0, 6'd8,  32'h10001248, 6'd0,  32'h0},
        '{32'h10000080, 2'd0, 1'b1, 6'd8,  32'h10001248, 6'd0,  32'h0},
        '{32'h00401000, 2'd0, 1'b0, 6'd12, 32'h00480000, 6'd24, 32'h00012340},
        '{32'hFF800000, 2'd0, 1'b0, 6'd32, 32'hFFE01000, 6'd48, 32'hFFF01000},
        '{32'h10000080, 2'd2, 1'b0, 6'd0,  32'h10003000, 6'd60, 32'h10004040}
    };
    localparam string VTAG [0:NV-1] = '{"R2", "R9", "R8", "R2", "R6", "R5", "R3", "R4", "R11"};
    localparam int VCNT [0:NV-1] = '{1, 1, 2, 0, 0, 0, 1, 1, 2};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fill_valid = 1'b0;
    logic         fill_ready;
    logic [511:0] fill_line = '0;
    logic [31:0]  fill_vaddr = '0;
    logic [1:0]   fill_depth = '0;
    logic         fill_walk = 1'b0;
    logic         req_valid;
    logic         req_ready = 1'b1;
    logic [31:0]  req_addr;
    logic [1:0]   req_depth;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_addr [0:31];
    int exp_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_line_scanner i_ptr_line_scanner (
        .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_ready(fill_ready),
        .fill_line(fill_line), .fill_vaddr(fill_vaddr), .fill_depth(fill_depth),
        .fill_walk(fill_walk), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_depth(req_depth)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Reference scan written from the requirements.
    task automatic model(input logic [511:0] line, input logic [31:0] va,
                         input logic [1:0] dep, input logic walk);
        exp_n = 0;
        if (walk || dep == 2'd3) return;
        for (int o = 0; o <= 60; o += 2) begin
            logic [31:0] w;
            logic [31:0] ln;
            bit q;
            bit dup;
            w = line[o*8 +: 32];
            q = (w[31:24] == va[31:24]) && !w[0];
            if (w[31:24] == 8'h00) q = q && (w[23:20] != 4'h0);
            if (w[31:24] == 8'hFF) q = q && (w[23:20] != 4'hF);
            ln = {w[31:6], 6'b0};
            dup = 1'b0;
            for (int k = 0; k < exp_n; k++) if (exp_addr[k] == ln) dup = 1'b1;
            if (q && !dup) begin
                exp_addr[exp_n] = ln;
                exp_n++;
            end
        end
    endtask

    // Present one fill; returns after the accepting edge, at a negedge.
    task automatic send(input logic [511:0] line, input logic [31:0] va,
                        input logic [1:0] dep, input logic walk);
        @(negedge clk);
        chk(fill_ready == 1'b1, "R10 fill_ready before fill", 32'(fill_ready), 32'd1);
        fill_line = line; fill_vaddr = va; fill_depth = dep; fill_walk = walk;
        fill_valid = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic drain(input string tag, input logic [1:0] dep);
        for (int k = 0; k < exp_n; k++) begin
            chk(req_valid == 1'b1, {tag, " R8 req_valid"}, 32'(req_valid), 32'd1);
            chk(req_addr == exp_addr[k], {tag, " R7 req_addr"}, req_addr, exp_addr[k]);
            chk(req_depth == dep + 2'd1, {tag, " R7 req_depth"}, 32'(req_depth), 32'(dep + 2'd1));
            @(negedge clk);
        end
        chk(req_valid == 1'b0, {tag, " R8 no extra request"}, 32'(req_valid), 32'd0);
        chk(fill_ready == 1'b1, {tag, " R10 fill_ready after drain"}, 32'(fill_ready), 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [511:0] line;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b0, "R1 req_valid after reset", 32'(req_valid), 32'd0);
        chk(fill_ready == 1'b1, "R1 fill_ready after reset", 32'(fill_ready), 32'd1);

        for (int v = 0; v < NV; v++) begin
            line = '0;
            if (VECS[v].v0 != 0) line[VECS[v].o0*8 +: 32] = VECS[v].v0;
            if (VECS[v].v1 != 0) line[VECS[v].o1*8 +: 32] = VECS[v].v1;
            model(line, VECS[v].va, VECS[v].dep, VECS[v].walk);
            chk(exp_n == VCNT[v], {VTAG[v], " model count"}, 32'(exp_n), 32'(VCNT[v]));
            send(line, VECS[v].va, VECS[v].dep, VECS[v].walk);
            drain(VTAG[v], VECS[v].dep);
        end

        // R10 and R11: 16 distinct pointers, consumer stalled first.
        line = '0;
        for (int k = 0; k < 16; k++) line[k*32 +: 32] = 32'h10000000 | (32'(k) << 6);
        model(line, 32'h10000000, 2'd0, 1'b0);
        chk(exp_n == 16, "R11 model count", 32'(exp_n), 32'd16);
        req_ready = 1'b0;
        send(line, 32'h10000000, 2'd0, 1'b0);
        chk(req_valid == 1'b1, "R10 valid under stall", 32'(req_valid), 32'd1);
        chk(req_addr == 32'h10000000, "R10 first addr under stall", req_addr, 32'h10000000);
        fill_line = '0; fill_line[31:0] = 32'h10007000; fill_valid = 1'b1;
        repeat (3) @(negedge clk);
        fill_valid = 1'b0;
        chk(req_addr == 32'h10000000, "R10 addr held", req_addr, 32'h10000000);
        chk(fill_ready == 1'b0, "R10 fill_ready low while busy", 32'(fill_ready), 32'd0);
        req_ready = 1'b1;
        drain("R11", 2'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule